// File: doc/BRIEF.md
# Line Event Status Bank with Interrupt Masking

This block collects line events from external framer devices into a bank of sticky status bits and turns them into one interrupt request for the host. Each event input is synchronised into the bus clock domain and edge-detected. A rising edge sets the matching status bit, and the bit then stays set. Software reads the status bits over a small register bus. Each request on that bus is acknowledged in the following cycle.

Two control registers sit next to the status bank. The hold-clear register is level-held: a 1 in a bit clears the matching status bit and keeps it cleared while the 1 stays there. Writing that bit back to 0 re-arms capture. The enable register chooses which status bits may raise the interrupt. The interrupt leaves the block in two registered forms: a level, and a one-cycle pulse on each new assertion of that level. The pulse suits a message-signalled interrupt path that expects one message per new assertion.

Top module: `line_evt_irq`

## Requirements
- R1: After reset the status bits, hold-clear bits and enable bits all read 0, and `irq_level`, `irq_pulse` and `ack` are all 0.
- R2: If an event input is 0 and is first sampled at 1 on clock edge k, the matching status bit reads 1 from edge k+2 onward. The bit stays 1 after the input returns to 0.
- R3: Writing 1 to a hold-clear bit (address 1) clears the matching status bit on the same edge. The bit stays 0 for as long as the hold-clear bit is 1, whatever new edges arrive on that event.
- R4: Writing 0 to a hold-clear bit re-arms capture. Only a rising edge after the re-arm sets the status bit again: an input that is still high from before does not.
- R5: If an event edge would set a status bit on the same edge that a write places 1 in its hold-clear bit, the bit ends at 0. Other bits that see an edge on that same edge still set.
- R6: `irq_level` equals the OR over all bits of (status AND enable), delayed by one register. An enable bit of 1 (address 2) lets its status bit contribute.
- R7: `irq_pulse` is high for exactly one cycle, in the same cycle that `irq_level` rises from 0 to 1. It does not fire again while `irq_level` stays high.
- R8: Every cycle in which `req_valid` is high is followed by exactly one cycle with `ack` high. `ack` is low after every cycle without a request.
- R9: Reads of address 1 and address 2 return the last value written there. Reads of address 0 return the status bits. Reads of address 3 return 0. Writes to address 0 or address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | N_EVT | Raw line event inputs, asynchronous |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select: 0 status, 1 hold-clear, 2 enable, 3 spare |
| req_wdata | input | N_EVT | Write data |
| ack | output | 1 | Acknowledge, one cycle after the request |
| rdata | output | N_EVT | Read data, valid with `ack` |
| irq_level | output | 1 | Registered masked-OR interrupt level |
| irq_pulse | output | 1 | One-cycle pulse on a rising `irq_level` |

## Verification
The assertions take for granted that every event input is either held steady or moved only at points well away from the clock edge, so the synchroniser never captures a changing value, and that `req_addr` is always one of the four defined codes. The bench changes inputs only on the falling clock edge. It holds each event level for several cycles, so every edge passes through the synchroniser cleanly, and it drives only the four decoded addresses. The one place where it aims a bus write at the exact edge where a synchronised event lands is the clear-priority case.

// File: rtl/evt_pkg.sv
// Package: shared register selector codes for the line event status bank.
// Assumes a two-bit register address on the bus.
package evt_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_ENABLE = 2'd2,
        REG_SPARE  = 2'd3
    } evt_reg_e;

endpackage

// File: rtl/evt_sync_edge.sv
// Module: evt_sync_edge
// Brings N_EVT asynchronous event lines into the clock domain through a chain
// of SYNC_STAGES flops per bit, then flags a one-cycle rise per bit.
// Assumes each input stays steady long enough to be seen by the first stage.
module evt_sync_edge #(
    parameter int N_EVT       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] raw_in,
    output logic [N_EVT-1:0] rise
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [N_EVT-1:0] stage_q [SYNC_STAGES];
    logic [N_EVT-1:0] prev_q;

    // First stage captures the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= raw_in;
        end
    end

    // Later stages pass the value down the chain.
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    // Remember the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= stage_q[LAST];
        end
    end

    // Flag a bit that is newly high in the synchronised domain.
    always_comb begin
        rise = stage_q[LAST] & ~prev_q;
    end

endmodule

// File: rtl/evt_status_bank.sv
// Module: evt_status_bank
// Sticky status bits: a rise sets a bit and it then holds. A hold-clear
// vector forces bits to zero and takes priority over a rise on the same edge.
// Assumes clr_next already carries a hold-clear write that lands this cycle.
module evt_status_bank #(
    parameter int N_EVT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] rise,
    input  logic [N_EVT-1:0] clr_next,
    output logic [N_EVT-1:0] status_q
);

    logic [N_EVT-1:0] status_d;

    // Per bit: set on a rise, hold otherwise, and let the clear win.
    for (genvar b = 0; b < N_EVT; b++) begin : g_bit
        always_comb begin
            if (clr_next[b]) begin
                status_d[b] = 1'b0;
            end else begin
                status_d[b] = status_q[b] | rise[b];
            end
        end
    end

    // Register the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/evt_regbus.sv
// Module: evt_regbus
// Register bus side: holds the hold-clear and enable registers, answers reads
// and acknowledges every request one cycle later.
// Assumes req_addr is one of the four codes in evt_pkg.
module evt_regbus
    import evt_pkg::*;
#(
    parameter int N_EVT = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [N_EVT-1:0]      req_wdata,
    input  logic [N_EVT-1:0]      status_q,
    output logic [N_EVT-1:0]      clr_q,
    output logic [N_EVT-1:0]      clr_next,
    output logic [N_EVT-1:0]      en_q,
    output logic                  ack,
    output logic [N_EVT-1:0]      rdata
);

    evt_reg_e         sel;
    logic             wr_clr;
    logic             wr_en;
    logic             rd_req;
    logic [N_EVT-1:0] rd_mux;

    // Decode the request into per-register strobes.
    always_comb begin
        sel    = evt_reg_e'(req_addr);
        wr_clr = req_valid && req_write && (sel == REG_CLEAR);
        wr_en  = req_valid && req_write && (sel == REG_ENABLE);
        rd_req = req_valid && !req_write;
    end

    // Next hold-clear value, shared with the status bank so the clear wins.
    always_comb begin
        clr_next = wr_clr ? req_wdata : clr_q;
    end

    // Select the read data.
    always_comb begin
        unique case (sel)
            REG_STATUS: rd_mux = status_q;
            REG_CLEAR:  rd_mux = clr_q;
            REG_ENABLE: rd_mux = en_q;
            default:    rd_mux = '0;
        endcase
    end

    // Hold-clear register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= '0;
        end else begin
            clr_q <= clr_next;
        end
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= req_wdata;
        end
    end

    // Acknowledge and read data, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= req_valid;
            rdata <= rd_req ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/evt_irq_gen.sv
// Module: evt_irq_gen
// Combines the enabled status bits into one registered level and a one-cycle
// pulse on each new assertion of that level.
// Assumes status and enable are both registered upstream.
module evt_irq_gen #(
    parameter int N_EVT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] status_q,
    input  logic [N_EVT-1:0] en_q,
    output logic             irq_level,
    output logic             irq_pulse
);

    logic any_hit;

    // OR-reduce the enabled status bits.
    always_comb begin
        any_hit = |(status_q & en_q);
    end

    // Register the level and mark its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_level <= any_hit;
            irq_pulse <= any_hit & ~irq_level;
        end
    end

endmodule

// File: rtl/line_evt_irq.sv
// Module: line_evt_irq (top)
// Line event status bank with a level-held clear register, an interrupt enable
// register and a registered interrupt level and pulse.
// Assumes N_EVT equals the bus data width and one register bus clock domain.
module line_evt_irq
    import evt_pkg::*;
#(
    parameter int N_EVT       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_EVT-1:0]      evt_in,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [N_EVT-1:0]      req_wdata,
    output logic                  ack,
    output logic [N_EVT-1:0]      rdata,
    output logic                  irq_level,
    output logic                  irq_pulse
);

    logic [N_EVT-1:0] rise;
    logic [N_EVT-1:0] status_q;
    logic [N_EVT-1:0] clr_q;
    logic [N_EVT-1:0] clr_next;
    logic [N_EVT-1:0] en_q;

    evt_sync_edge #(.N_EVT(N_EVT), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (evt_in),
        .rise   (rise)
    );

    evt_status_bank #(.N_EVT(N_EVT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .clr_next (clr_next),
        .status_q (status_q)
    );

    evt_regbus #(.N_EVT(N_EVT)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .status_q  (status_q),
        .clr_q     (clr_q),
        .clr_next  (clr_next),
        .en_q      (en_q),
        .ack       (ack),
        .rdata     (rdata)
    );

    evt_irq_gen #(.N_EVT(N_EVT)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_q  (status_q),
        .en_q      (en_q),
        .irq_level (irq_level),
        .irq_pulse (irq_pulse)
    );

endmodule

// File: rtl/line_evt_irq_chk.sv
// Module: line_evt_irq_chk
// Property checker for line_evt_irq, attached through the bind below.
// Assumes the observed registers are the top's internal state vectors.
module line_evt_irq_chk #(
    parameter int N_EVT = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             ack,
    input logic             irq_level,
    input logic             irq_pulse,
    input logic [N_EVT-1:0] status_q,
    input logic [N_EVT-1:0] clr_q,
    input logic [N_EVT-1:0] en_q
);

    // R8
    ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ack);

    // R8
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ack);

    // R3
    held_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & clr_q) == '0);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~status_q & ~clr_q) == '0));

    // R6
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & en_q)) |=> irq_level);

    // R6
    level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_q & en_q)) |=> !irq_level);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R7
    pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (irq_level && !$past(irq_level)));

endmodule

bind line_evt_irq line_evt_irq_chk #(.N_EVT(N_EVT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ack       (ack),
    .irq_level (irq_level),
    .irq_pulse (irq_pulse),
    .status_q  (status_q),
    .clr_q     (clr_q),
    .en_q      (en_q)
);

// File: tb/line_evt_irq_test.sv
`timescale 1ns/1ps
module line_evt_irq_test;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_in = '0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [1:0]   req_addr = '0;
    logic [N-1:0] req_wdata = '0;
    logic         ack;
    logic [N-1:0] rdata;
    logic         irq_level;
    logic         irq_pulse;

    int total = 0;
    int bad = 0;
    int pulse_cnt = 0;

    line_evt_irq #(.N_EVT(N)) uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .irq_level(irq_level), .irq_pulse(irq_pulse)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && irq_pulse) pulse_cnt++;
    end

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [N-1:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        check("R8 write ack", {31'b0, ack}, 32'd1);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [N-1:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); @(negedge clk);
        check("R8 read ack", {31'b0, ack}, 32'd1);
        d = rdata;
        req_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] v;
        logic [N-1:0] en_pat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_level", {31'b0, irq_level}, 0);
        check("R1 irq_pulse", {31'b0, irq_pulse}, 0);
        check("R1 ack", {31'b0, ack}, 0);
        bus_rd(2'd0, v); check("R1 status", v, 0);
        bus_rd(2'd1, v); check("R1 hold-clear", v, 0);
        bus_rd(2'd2, v); check("R1 enable", v, 0);
        @(negedge clk);
        check("R8 idle ack low", {31'b0, ack}, 0);

        // R9 readback and ignored writes
        bus_wr(2'd2, 32'hA5A5_0F0F);
        bus_rd(2'd2, v); check("R9 enable readback", v, 32'hA5A5_0F0F);
        bus_wr(2'd1, 32'h0000_F00F);
        bus_rd(2'd1, v); check("R9 clear readback", v, 32'h0000_F00F);
        bus_wr(2'd1, 32'h0);
        bus_wr(2'd0, 32'hFFFF_FFFF);
        bus_rd(2'd0, v); check("R9 status write ignored", v, 0);
        bus_wr(2'd3, 32'h1234_5678);
        bus_rd(2'd3, v); check("R9 spare reads zero", v, 0);
        bus_rd(2'd2, v); check("R9 spare write ignored", v, 32'hA5A5_0F0F);
        bus_rd(2'd1, v); check("R9 clear after spare write", v, 0);

        // Sweep every event bit under a mixed enable pattern
        en_pat = 32'h3C96_A55A;
        bus_wr(2'd2, en_pat);
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] one;
            one = 32'd1 << i;
            pulse_cnt = 0;
            evt_in = one;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R6 level not yet", {31'b0, irq_level}, 0);
            @(negedge clk);
            check("R6 level", {31'b0, irq_level}, {31'b0, en_pat[i]});
            check("R7 pulse", {31'b0, irq_pulse}, {31'b0, en_pat[i]});
            @(negedge clk);
            check("R7 pulse one cycle", {31'b0, irq_pulse}, 0);
            evt_in = '0;
            wait_cyc(3);
            bus_rd(2'd0, v); check("R2 sticky status", v, one);
            check("R7 pulse count", pulse_cnt, {31'b0, en_pat[i]});
            bus_wr(2'd1, one);
            bus_rd(2'd0, v); check("R3 cleared", v, 0);
            check("R6 level after clear", {31'b0, irq_level}, 0);
            evt_in = one;
            wait_cyc(5);
            evt_in = '0;
            wait_cyc(3);
            bus_rd(2'd0, v); check("R3 held clear ignores event", v, 0);
            bus_wr(2'd1, 32'h0);
            bus_rd(2'd0, v); check("R4 re-arm alone", v, 0);
            evt_in = one;
            wait_cyc(5);
            bus_rd(2'd0, v); check("R4 re-armed capture", v, one);
            bus_wr(2'd1, one);
            bus_wr(2'd1, 32'h0);
            wait_cyc(4);
            bus_rd(2'd0, v); check("R4 high level no new edge", v, 0);
            evt_in = '0;
            wait_cyc(3);
        end

        // R5 clear write on the same edge as a synchronised rise
        bus_wr(2'd2, 32'h0);
        @(negedge clk);
        evt_in = 32'h0000_0180;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd1; req_wdata = 32'h0000_0080;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        bus_rd(2'd0, v); check("R5 clear wins, neighbour sets", v, 32'h0000_0100);
        bus_wr(2'd1, 32'h0);
        wait_cyc(3);
        bus_rd(2'd0, v); check("R5 no late set after release", v, 32'h0000_0100);
        evt_in = '0;
        bus_wr(2'd1, 32'h0000_0100);
        bus_wr(2'd1, 32'h0);

        // R7 second enabled event while level high gives no new pulse
        bus_wr(2'd2, 32'hFFFF_FFFF);
        pulse_cnt = 0;
        evt_in = 32'h0000_0008;
        wait_cyc(6);
        evt_in = 32'h0000_0208;
        wait_cyc(6);
        check("R7 one pulse for two events", pulse_cnt, 1);
        check("R6 level high", {31'b0, irq_level}, 1);
        evt_in = '0;
        bus_wr(2'd1, 32'h0000_0208);
        wait_cyc(2);
        check("R6 level low after clear", {31'b0, irq_level}, 0);
        bus_wr(2'd1, 32'h0);
        evt_in = 32'h0000_0200;
        wait_cyc(6);
        check("R7 new pulse after fall", pulse_cnt, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule